// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This unit sits between the execute stage of a processor and a data memory that is one 32-bit word wide. Each cycle it can accept one access. An access gives a base register value, a signed 16-bit displacement, a size (byte or word), a direction (load or store) and store data. The unit forms the effective byte address from these inputs. It then drives the word address, a per-lane byte-enable mask and lane-placed write data toward the memory.

Byte lanes follow big-endian order. The byte at the lowest address of a word is carried on the most significant lane.

The memory answers a load one cycle after the request. The unit keeps the size, signedness and lane of the pending load in registers. In the cycle the data comes back, it returns either the whole word, or the selected byte extended to 32 bits with its sign or with zeros. A word access whose effective address is not a multiple of four is flagged. Such an access is not sent to memory, so it writes nothing and returns nothing.

Top module: `be_lsu_lane`

## Requirements
- R1: The effective address is base_i plus offset_i sign-extended to 32 bits, wrapping modulo 2^32. mem_addr_o carries effective address bits 31:2.
- R2: A requested word access whose effective address has nonzero bits 1:0 drives misaligned_o high in the same cycle. mem_req_o and mem_we_o stay low, and load_valid_o stays low in the next cycle. Byte accesses never raise misaligned_o.
- R3: For a word access mem_be_o is 4'b1111. For a byte access at lane offset k (effective address bits 1:0) only bit 3-k is set: offset 0 gives 4'b1000 and offset 3 gives 4'b0001.
- R4: A word store drives wdata_i unchanged on mem_wdata_o. A byte store copies wdata_i[7:0] into all four byte lanes, so the enabled lane carries it. Offset 0 is bits 31:24 and offset 3 is bits 7:0.
- R5: An accepted access (req_i high, not misaligned) raises mem_req_o. mem_we_o is high only for an accepted store.
- R6: load_valid_o is high in exactly the cycle after an accepted load, and low otherwise. load_data_o is formed in that cycle from mem_rdata_i.
- R7: A word load returns mem_rdata_i unchanged. unsigned_i has no effect on word loads.
- R8: A signed byte load at offset k takes mem_rdata_i bits [31-8k -: 8] and fills bits 31:8 with bit 7 of that byte.
- R9: A byte load with unsigned_i high returns the selected byte with bits 31:8 cleared.
- R10: While rst_ni is low, load_valid_o is low. After release it stays low until an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_word_i | input | 1 | 1 = word access, 0 = byte access |
| unsigned_i | input | 1 | Zero-extend byte loads |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store data (byte stores use bits 7:0) |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata_o | output | 32 | Lane-placed write data |
| mem_rdata_i | input | 32 | Memory read word, one cycle after request |
| misaligned_o | output | 1 | Misaligned word access flag |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The bench covers all four byte offsets for loads and stores. A design with little-endian lanes would enable the wrong mask bit and return the byte from the opposite end of the word. Negative displacements and wrap-around below address zero expose a displacement that is zero-extended rather than sign-extended. Bytes with bit 7 set, loaded both signed and unsigned, catch a missing or inverted extension. Misaligned word loads and stores expose a design that still writes memory or still reports a load result.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic {SZ_BYTE = 1'b0, SZ_WORD = 1'b1} acc_size_e;

  typedef struct packed {
    logic      valid;
    acc_size_e size;
    logic      uns;
  } ld_ctx_t;
endpackage

// File: rtl/lsu_agu.sv
module lsu_agu #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] ea_o
);
  localparam int unsigned EXT_W = DATA_W - OFF_W;

  logic [DATA_W-1:0] off_ext;
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign ea_o    = base_i + off_ext;
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(BYTES)
) (
  input  acc_size_e         size_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BYTES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  // big-endian: lane k drives enable bit BYTES-1-k
  for (genvar k = 0; k < BYTES; k++) begin : g_be
    assign be_o[BYTES-1-k] = (size_i == SZ_WORD) || (lane_i == LANE_W'(k));
  end

  assign wdata_o = (size_i == SZ_WORD) ? wdata_i : {BYTES{wdata_i[7:0]}};
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(BYTES)
) (
  input  acc_size_e         size_i,
  input  logic              uns_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0] lanes [BYTES];
  logic [7:0] sel;
  logic       fill;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign lanes[k] = rdata_i[DATA_W-1-8*k -: 8];
  end

  assign sel  = lanes[lane_i];
  assign fill = ~uns_i & sel[7];

  always_comb begin
    if (size_i == SZ_WORD) data_o = rdata_i;
    else                   data_o = {{(DATA_W-8){fill}}, sel};
  end
endmodule

// File: rtl/be_lsu_lane.sv
module be_lsu_lane
  import lsu_lane_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 16,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(BYTES),
  localparam int unsigned WA_W   = DATA_W - LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              size_word_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WA_W-1:0]   mem_addr_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misaligned_o,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o
);
  logic [DATA_W-1:0] ea;
  logic [LANE_W-1:0] lane;
  acc_size_e         size;
  logic              accept;
  ld_ctx_t           ctx_q;
  logic [LANE_W-1:0] lane_q;

  assign size = acc_size_e'(size_word_i);

  lsu_agu #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_agu (
    .base_i (base_i),
    .off_i  (offset_i),
    .ea_o   (ea)
  );

  assign lane         = ea[LANE_W-1:0];
  assign misaligned_o = req_i && (size == SZ_WORD) && (lane != '0);
  assign accept       = req_i && !misaligned_o;
  assign mem_req_o    = accept;
  assign mem_we_o     = accept && we_i;
  assign mem_addr_o   = ea[DATA_W-1:LANE_W];

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .size_i  (size),
    .lane_i  (lane),
    .wdata_i (wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  // context of the load whose data returns next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q  <= '{valid: 1'b0, size: SZ_BYTE, uns: 1'b0};
      lane_q <= '0;
    end else begin
      ctx_q.valid <= accept && !we_i;
      if (accept && !we_i) begin
        ctx_q.size <= size;
        ctx_q.uns  <= unsigned_i;
        lane_q     <= lane;
      end
    end
  end

  assign load_valid_o = ctx_q.valid;

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i  (ctx_q.size),
    .uns_i   (ctx_q.uns),
    .lane_i  (lane_q),
    .rdata_i (mem_rdata_i),
    .data_o  (load_data_o)
  );
endmodule

// File: rtl/be_lsu_lane_chk.sv
module be_lsu_lane_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BYTES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              size_word_i,
  input logic              unsigned_i,
  input logic              misaligned_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [BYTES-1:0]  mem_be_o,
  input logic              load_valid_o,
  input logic [DATA_W-1:0] load_data_o
);
  assert_misaligned_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> (!mem_req_o && !mem_we_o));

  assert_misaligned_no_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |=> !load_valid_o);

  assert_byte_one_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !size_word_i) |-> ($countones(mem_be_o) == 1));

  assert_word_all_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && size_word_i) |-> (mem_be_o == '1));

  assert_we_implies_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  assert_load_valid_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> load_valid_o);

  assert_load_valid_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !mem_we_o) |=> !load_valid_o);

  assert_sign_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_o && $past(!size_word_i && !unsigned_i))
      |-> (load_data_o[DATA_W-1:8] == {(DATA_W-8){load_data_o[7]}}));

  assert_zero_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_o && $past(!size_word_i && unsigned_i))
      |-> (load_data_o[DATA_W-1:8] == '0));
endmodule

bind be_lsu_lane be_lsu_lane_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .size_word_i  (size_word_i),
  .unsigned_i   (unsigned_i),
  .misaligned_o (misaligned_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .load_valid_o (load_valid_o),
  .load_data_o  (load_data_o)
);

// File: tb/be_lsu_lane_bench.sv
module be_lsu_lane_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, size_word_i = 1'b0, unsigned_i = 1'b0;
  logic [31:0] base_i = '0, wdata_i = '0, mem_rdata_i = '0;
  logic [15:0] offset_i = '0;
  logic        mem_req_o, mem_we_o, misaligned_o, load_valid_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, load_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  be_lsu_lane u_be_lsu_lane (.*);

  typedef struct packed {
    logic        we;
    logic        word;
    logic        uns;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] wdata;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b0, 32'h0000_1000, 16'h0020, 32'hDEAD_BEEF, 32'h0},
    '{1'b1, 1'b0, 1'b0, 32'h0000_2000, 16'h0005, 32'h1234_56AB, 32'h0},
    '{1'b1, 1'b0, 1'b0, 32'h0000_2000, 16'h0003, 32'h0000_00C3, 32'h0},
    '{1'b0, 1'b0, 1'b0, 32'h0000_3000, 16'h0000, 32'h0,         32'h8012_3456},
    '{1'b0, 1'b0, 1'b0, 32'h0000_3004, 16'hFFFF, 32'h0,         32'h1234_567F},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0100, 16'h0002, 32'h0,         32'h0000_9A00},
    '{1'b0, 1'b0, 1'b0, 32'h0000_0101, 16'h0000, 32'h0,         32'h00F1_0000},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0040, 16'hFFFC, 32'h0,         32'hCAFE_F00D},
    '{1'b0, 1'b1, 1'b1, 32'h0000_0040, 16'h0000, 32'h0,         32'h8765_4321},
    '{1'b1, 1'b1, 1'b0, 32'h0000_0010, 16'h0002, 32'h5555_AAAA, 32'h0},
    '{1'b0, 1'b1, 1'b0, 32'h0000_0011, 16'h0000, 32'h0,         32'h1111_1111},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 16'hFFFD, 32'h0,         32'hFFFF_FFFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  function automatic logic [3:0] m_be(input logic word, input logic [1:0] k);
    if (word) return 4'b1111;
    case (k)
      2'd0: return 4'b1000;
      2'd1: return 4'b0100;
      2'd2: return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [31:0] m_load(input logic word, input logic uns,
                                         input logic [1:0] k, input logic [31:0] rd);
    logic [7:0] b;
    if (word) return rd;
    case (k)
      2'd0: b = rd[31:24];
      2'd1: b = rd[23:16];
      2'd2: b = rd[15:8];
      default: b = rd[7:0];
    endcase
    if (uns) return {24'h0, b};
    return {{24{b[7]}}, b};
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] ea;
    logic        mis;
    ea  = v.base + {{16{v.off[15]}}, v.off};
    mis = v.word && (ea[1:0] != 2'b00);
    @(negedge clk_i);
    req_i = 1'b1; we_i = v.we; size_word_i = v.word; unsigned_i = v.uns;
    base_i = v.base; offset_i = v.off; wdata_i = v.wdata;
    #1;
    chk("R2 misaligned", 32'(misaligned_o), 32'(mis));
    chk("R5 mem_req", 32'(mem_req_o), 32'(!mis));
    chk("R5 mem_we", 32'(mem_we_o), 32'(!mis && v.we));
    chk("R1 mem_addr", 32'(mem_addr_o), 32'(ea[31:2]));
    if (!mis) chk("R3 mem_be", 32'(mem_be_o), 32'(m_be(v.word, ea[1:0])));
    if (!mis && v.we)
      chk("R4 mem_wdata", mem_wdata_o, v.word ? v.wdata : {4{v.wdata[7:0]}});
    @(negedge clk_i);
    req_i = 1'b0;
    mem_rdata_i = v.rdata;
    #1;
    chk("R6 load_valid", 32'(load_valid_o), 32'(!mis && !v.we));
    if (!mis && !v.we) begin
      if (v.word)      chk("R7 word load", load_data_o, m_load(1'b1, v.uns, 2'd0, v.rdata));
      else if (v.uns)  chk("R9 unsigned byte load", load_data_o, m_load(1'b0, 1'b1, ea[1:0], v.rdata));
      else             chk("R8 signed byte load", load_data_o, m_load(1'b0, 1'b0, ea[1:0], v.rdata));
    end
  endtask

  initial begin
    #1;
    chk("R10 reset load_valid", 32'(load_valid_o), 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R10 after release", 32'(load_valid_o), 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // directed: hand-computed corners
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; size_word_i = 1'b0; unsigned_i = 1'b0;
    base_i = 32'h0000_0000; offset_i = 16'hFFFC;
    #1;
    chk("R1 wrap below zero", 32'(mem_addr_o), 32'h3FFF_FFFF);
    chk("R3 offset0 is msb lane", 32'(mem_be_o), 32'h8);
    @(negedge clk_i);
    req_i = 1'b0; mem_rdata_i = 32'h80FF_FFFF;
    #1;
    chk("R8 bit7 set offset0", load_data_o, 32'hFFFF_FF80);
    @(negedge clk_i);
    #1;
    chk("R6 single cycle valid", 32'(load_valid_o), 32'h0);

    // byte store at offset 3 lands in lowest lane
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; size_word_i = 1'b0;
    base_i = 32'h0000_0007; offset_i = 16'h0000; wdata_i = 32'h0000_005A;
    #1;
    chk("R3 offset3 be", 32'(mem_be_o), 32'h1);
    chk("R4 offset3 lane", 32'(mem_wdata_o[7:0]), 32'h5A);
    @(negedge clk_i);
    req_i = 1'b0;
    #1;
    chk("R6 no valid after store", 32'(load_valid_o), 32'h0);

    // misaligned byte-size access is never flagged
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; size_word_i = 1'b0; base_i = 32'h0000_0003; offset_i = '0;
    #1;
    chk("R2 byte never misaligned", 32'(misaligned_o), 32'h0);
    @(negedge clk_i);
    req_i = 1'b0;

    // reset while a load is pending
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; size_word_i = 1'b1; base_i = 32'h0000_0020; offset_i = '0;
    @(negedge clk_i);
    req_i = 1'b0; rst_ni = 1'b0;
    #1;
    chk("R10 reset clears valid", 32'(load_valid_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule